// File: doc/BRIEF.md
# Multi-Source Reset Supervisor

This block produces the system reset for a chip from a handful of digital cause signals: a main-supply comparator flag, an auxiliary set of rail comparator flags, a manual reset pin and the power-on indication, which is the block's own synchronous reset. The main reset is asserted while any cause is present. It is then held for a selectable stretch period after the last cause clears, so that supplies and clocks settle before software starts. The manual pin is debounced before it can act. Active-high and active-low forms of the reset leave the block together.

Two kinds of output deliberately skip the stretch timer. The first is an early low-supply warning that tracks the main-supply flag. The second is a set of rail-fail outputs, one per auxiliary comparator. Each follows its input one clock later, whatever the reset state is. A sticky fault register records which causes have appeared since it was last cleared. Software or a neighbouring block can clear any bit with a write-one-to-clear strobe. All comparator flags are expected to be synchronous to the block clock already.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `sys_rst_o` is 1. After `rst` falls, with no cause present, `sys_rst_o` stays 1 for exactly N clock edges and then reads 0. N is the stretch length selected by `tsel_i`. Edges are counted from the first edge that samples `rst` low.
- R2: A 0 on `supply_ok_i` makes `sys_rst_o` 1 at the next edge. It stays 1 while the flag is 0 and for exactly N edges after the first edge that samples the flag back at 1.
- R3: Once the debounced manual level is low (asserted), `sys_rst_o` is 1 from the next edge. It stays 1 until the debounced level returns high and then for N further edges.
- R4: `mreset_n_i` is sampled once every TICK_DIV clocks. A new level is accepted only after STABLE consecutive samples (16 by default) all differ from the accepted level. A disagreeing run shorter than that leaves the accepted level unchanged and has no effect on `sys_rst_o` or `fault_o`.
- R5: `tsel_i` values 0, 1, 2 and 3 select stretch lengths N of TBASE, 4·TBASE, 16·TBASE and 64·TBASE clocks.
- R6: `sys_rst_n_o` is the logical complement of `sys_rst_o` in every cycle.
- R7: `early_low_n_o` equals the value `supply_ok_i` had at the previous edge. This holds during `rst` as well, and the output has no stretch.
- R8: Each bit of `aux_fail_n_o` equals the value the matching bit of `aux_ok_i` had at the previous edge. The bits are unaffected by reset or by the stretch timer.
- R9: `fault_o` bit 0 records a low main supply, bit 1 a debounced manual reset, and bits 2 and up record a low on `aux_ok_i` bits 0 and up. A bit becomes 1 one edge after its cause is seen and then stays 1. All bits are 0 while `rst` is high.
- R10: A 1 on a bit of `fault_clr_i` clears the matching `fault_o` bit at the next edge. If the cause of that bit is present in the same cycle, the set wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; serves as the power-on indication |
| supply_ok_i | input | 1 | Main supply above its first trip point (1) or below it (0) |
| mreset_n_i | input | 1 | Manual reset pin, active low, not debounced |
| aux_ok_i | input | N_AUX | Auxiliary rail comparators, 1 = rail above trip |
| tsel_i | input | 2 | Stretch length select |
| fault_clr_i | input | N_AUX+2 | Write-one-to-clear strobe for the fault register |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| early_low_n_o | output | 1 | Early low-supply warning, low while supply is below trip |
| aux_fail_n_o | output | N_AUX | Auxiliary rail fail, low while the rail is below trip |
| fault_o | output | N_AUX+2 | Sticky record of reset causes |

## Verification
The assertions take for granted that every comparator flag and the clear strobe are already synchronous to the clock. They also assume that `tsel_i` does not change while a stretch is running, because a change mid-count would move the release edge that the reset properties reason about. The stimulus drives all inputs on the falling clock edge. It changes `tsel_i` only while a supply dip holds the stretch counter at zero. Manual pulses are either well below or well above the debounce window, so no accepted level lands on an ambiguous edge.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  // Bit positions inside the fault register
  localparam int unsigned FLT_SUPPLY = 0;
  localparam int unsigned FLT_MANUAL = 1;
  localparam int unsigned FLT_AUX0   = 2;

  // Stretch length for a given select value: base, 4x, 16x, 64x
  function automatic int unsigned stretch_len(input int unsigned base,
                                              input logic [1:0] sel);
    return base << (2 * int'(sel));
  endfunction

endpackage

// File: rtl/rsv_debounce.sv
module rsv_debounce #(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned STABLE   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_n_i,
  output logic level_n_o
);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned SW = (STABLE > 1) ? $clog2(STABLE) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
  localparam logic [SW-1:0] RUN_LAST  = SW'(STABLE - 1);

  logic [TW-1:0] div_q;
  logic [SW-1:0] run_q;
  logic          acc_q;
  logic          tick;

  assign tick = (div_q == TICK_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 1'b1;
      run_q <= '0;
    end else if (tick) begin
      if (raw_n_i != acc_q) begin
        if (run_q == RUN_LAST) begin
          acc_q <= raw_n_i;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level_n_o = acc_q;
endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch #(
  parameter int unsigned TBASE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cause_i,
  input  logic [1:0] tsel_i,
  output logic       hold_o
);
  localparam int unsigned MAXLEN = TBASE * 64;
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          hold_q;

  always_comb last = CW'(rsv_pkg::stretch_len(TBASE, tsel_i) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (cause_i) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (hold_q) begin
      if (cnt_q >= last) begin
        cnt_q  <= '0;
        hold_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/rsv_fault.sv
module rsv_fault #(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] fault_o
);
  logic [NB-1:0] f_q;

  for (genvar b = 0; b < NB; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        f_q[b] <= 1'b0;
      end else begin
        f_q[b] <= (f_q[b] & ~clr_i[b]) | set_i[b];
      end
    end
  end

  assign fault_o = f_q;
endmodule

// File: rtl/rsv_follow.sv
module rsv_follow #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned TBASE    = 16,
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned STABLE   = 16,
  parameter int unsigned N_AUX    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok_i,
  input  logic             mreset_n_i,
  input  logic [N_AUX-1:0] aux_ok_i,
  input  logic [1:0]       tsel_i,
  input  logic [N_AUX+1:0] fault_clr_i,
  output logic             sys_rst_o,
  output logic             sys_rst_n_o,
  output logic             early_low_n_o,
  output logic [N_AUX-1:0] aux_fail_n_o,
  output logic [N_AUX+1:0] fault_o
);
  localparam int unsigned NF = N_AUX + 2;
  localparam int unsigned NW = N_AUX + 1;

  logic          man_n;
  logic          cause;
  logic          hold;
  logic [NF-1:0] set_vec;
  logic [NW-1:0] follow_q;

  rsv_debounce #(.TICK_DIV(TICK_DIV), .STABLE(STABLE)) i_deb (
    .clk      (clk),
    .rst      (rst),
    .raw_n_i  (mreset_n_i),
    .level_n_o(man_n)
  );

  assign cause = ~supply_ok_i | ~man_n;

  rsv_stretch #(.TBASE(TBASE)) i_str (
    .clk    (clk),
    .rst    (rst),
    .cause_i(cause),
    .tsel_i (tsel_i),
    .hold_o (hold)
  );

  assign sys_rst_o   = hold;
  assign sys_rst_n_o = ~hold;

  always_comb begin
    set_vec = '0;
    set_vec[rsv_pkg::FLT_SUPPLY] = ~supply_ok_i;
    set_vec[rsv_pkg::FLT_MANUAL] = ~man_n;
    for (int i = 0; i < int'(N_AUX); i++) begin
      set_vec[rsv_pkg::FLT_AUX0 + i] = ~aux_ok_i[i];
    end
  end

  rsv_fault #(.NB(NF)) i_flt (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_vec),
    .clr_i  (fault_clr_i),
    .fault_o(fault_o)
  );

  rsv_follow #(.W(NW)) i_fol (
    .clk(clk),
    .d_i({aux_ok_i, supply_ok_i}),
    .q_o(follow_q)
  );

  assign early_low_n_o = follow_q[0];
  assign aux_fail_n_o  = follow_q[NW-1:1];
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int unsigned N_AUX = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             supply_ok_i,
  input logic [N_AUX-1:0] aux_ok_i,
  input logic [N_AUX+1:0] fault_clr_i,
  input logic             sys_rst_o,
  input logic             early_low_n_o,
  input logic [N_AUX-1:0] aux_fail_n_o,
  input logic [N_AUX+1:0] fault_o
);
  assert_supply_low_resets_R2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> sys_rst_o);

  assert_release_needs_supply_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_o) |-> $past(supply_ok_i));

  assert_early_low_R7: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> !early_low_n_o);

  assert_early_high_R7: assert property (@(posedge clk) disable iff (rst)
    supply_ok_i |=> early_low_n_o);

  assert_aux_follow_R8: assert property (@(posedge clk) disable iff (rst)
    $changed(aux_ok_i) |=> (aux_fail_n_o == $past(aux_ok_i)));

  assert_supply_fault_set_R9: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> fault_o[0]);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (fault_o[0] && !fault_clr_i[0]) |=> fault_o[0]);
endmodule

bind rst_supervisor rsv_checker #(.N_AUX(N_AUX)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .supply_ok_i  (supply_ok_i),
  .aux_ok_i     (aux_ok_i),
  .fault_clr_i  (fault_clr_i),
  .sys_rst_o    (sys_rst_o),
  .early_low_n_o(early_low_n_o),
  .aux_fail_n_o (aux_fail_n_o),
  .fault_o      (fault_o)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  localparam int TBASE = 16;
  localparam int TICK  = 4;
  localparam int STAB  = 16;
  localparam int NA    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          supply_ok = 1'b1;
  logic          mr_n = 1'b1;
  logic [NA-1:0] aux_ok = '1;
  logic [1:0]    tsel = 2'd0;
  logic [NA+1:0] clr = '0;
  logic          sys_rst, sys_rst_n, early_n;
  logic [NA-1:0] aux_fail_n;
  logic [NA+1:0] fault;

  int checks = 0;
  int errors = 0;
  bit started = 0;

  always #10 clk = ~clk;

  rst_supervisor #(.TBASE(TBASE), .TICK_DIV(TICK), .STABLE(STAB), .N_AUX(NA)) i_rst_supervisor (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .mreset_n_i(mr_n),
    .aux_ok_i(aux_ok), .tsel_i(tsel), .fault_clr_i(clr),
    .sys_rst_o(sys_rst), .sys_rst_n_o(sys_rst_n), .early_low_n_o(early_n),
    .aux_fail_n_o(aux_fail_n), .fault_o(fault)
  );

  // Behavioural reference, advanced on each rising edge
  int m_div, m_run, m_cnt, m_lim;
  bit m_acc, m_hold, m_early, m_cause;
  bit [NA-1:0] m_aux;
  bit [NA+1:0] m_fault, m_set;

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_run = 0; m_acc = 1; m_cnt = 0; m_hold = 1; m_fault = '0;
    end else begin
      m_cause = !supply_ok || !m_acc;
      m_set   = {~aux_ok, !m_acc, !supply_ok};
      m_lim   = TBASE << (2 * int'(tsel));
      if (m_cause) begin
        m_cnt = 0; m_hold = 1;
      end else if (m_hold) begin
        if (m_cnt >= m_lim - 1) begin m_hold = 0; m_cnt = 0; end
        else m_cnt++;
      end
      m_fault = (m_fault & ~clr) | m_set;
      if (m_div == TICK - 1) begin
        m_div = 0;
        if (mr_n != m_acc) begin
          if (m_run == STAB - 1) begin m_acc = mr_n; m_run = 0; end
          else m_run++;
        end else m_run = 0;
      end else m_div++;
    end
    m_early = supply_ok;
    m_aux   = aux_ok;
    started = 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R1 R2 R3 sys_rst_o vs model", int'(sys_rst), int'(m_hold));
      chk("R6 sys_rst_n_o complement", int'(sys_rst_n), int'(!sys_rst));
      chk("R7 early_low_n_o", int'(early_n), int'(m_early));
      chk("R8 aux_fail_n_o", int'(aux_fail_n), int'(m_aux));
      chk("R9 fault_o vs model", int'(fault), int'(m_fault));
    end
  end

  // Count low-to-release edges once the last cause has cleared
  task automatic measure(input string tag, input int exp);
    int n = 0;
    while (sys_rst && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, n, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(4);
    chk("R1 reset held during rst", int'(sys_rst), 1);
    chk("R9 fault clear in rst", int'(fault), 0);
    rst = 1'b0;
    measure("R1 power-on stretch length", TBASE);
    cyc(5);

    // R2: supply dip
    supply_ok = 1'b0;
    cyc(1);
    chk("R2 reset asserted after dip", int'(sys_rst), 1);
    chk("R7 early warning low", int'(early_n), 0);
    cyc(6);
    supply_ok = 1'b1;
    measure("R2 stretch after recovery", TBASE);
    chk("R9 supply fault recorded", int'(fault[0]), 1);

    // R8: aux dips do not touch reset
    aux_ok = 2'b10;
    cyc(3);
    chk("R8 aux0 fail low", int'(aux_fail_n[0]), 0);
    chk("R8 reset unaffected", int'(sys_rst), 0);
    aux_ok = 2'b01;
    cyc(1);
    aux_ok = 2'b11;
    cyc(2);
    chk("R9 aux faults recorded", int'(fault[3:2]), 3);

    // R10: clear with cause gone, then with cause present
    clr = 4'b1101;
    cyc(1);
    clr = '0;
    chk("R10 cleared bits", int'(fault), 0);
    aux_ok = 2'b10;
    clr = 4'b0100;
    cyc(1);
    cyc(1);
    clr = '0;
    chk("R10 set wins over clear", int'(fault[2]), 1);
    aux_ok = 2'b11;
    cyc(2);

    // R4: short manual glitch ignored
    mr_n = 1'b0;
    cyc(TICK * STAB / 3);
    mr_n = 1'b1;
    cyc(TICK * STAB * 2);
    chk("R4 glitch no reset", int'(sys_rst), 0);
    chk("R4 glitch no manual fault", int'(fault[1]), 0);

    // R3: long manual press
    mr_n = 1'b0;
    cyc(TICK * STAB + 3 * TICK);
    chk("R3 manual reset active", int'(sys_rst), 1);
    chk("R9 manual fault recorded", int'(fault[1]), 1);
    cyc(20);
    mr_n = 1'b1;
    cyc(TICK * STAB - 2 * TICK);
    chk("R3 held until debounced release", int'(sys_rst), 1);
    cyc(TICK * STAB + TBASE + 8 * TICK);
    chk("R3 released after stretch", int'(sys_rst), 0);

    // R5: each stretch selection
    for (int s = 1; s < 4; s++) begin
      supply_ok = 1'b0;
      cyc(2);
      tsel = 2'(s);
      cyc(2);
      supply_ok = 1'b1;
      measure($sformatf("R5 stretch length sel %0d", s), TBASE << (2 * s));
      cyc(4);
    end

    // R1: power-on again with a longer selection
    tsel = 2'd1;
    rst = 1'b1;
    cyc(3);
    chk("R9 rst clears faults", int'(fault), 0);
    rst = 1'b0;
    measure("R1 power-on stretch sel 1", TBASE * 4);
    cyc(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule